// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block produces the timing for a serial master's shift clock from the bus clock. Two counters run in cascade. The first is a linear prescaler that divides by 1 to 8. The second is a power-of-two divider that divides by 2 to 256. The complete bit period is the product of the two divides. Each divide is chosen by its own 3-bit selection field, not by a single divide register.

The block has two outputs. The first is a half-period strobe, `sck_toggle`, which the shifter uses to flip its serial clock, so the clock has a 50% duty cycle. The second is a whole-bit strobe, `bit_tick`, which marks the end of each bit period.

While no master transfer is active, both counters are held cleared and the selection fields are captured on every clock edge. During a transfer, the captured values stay frozen. A change to the fields therefore applies only from the next transfer. Every transfer starts with a full first half-period. The block has no data path, so its pins are plain control and status signals with no valid/ready handshake and no back-pressure.

Top module: `spi_rate_gen`

## Requirements
- R1: While reset is asserted and in the cycles after release with `xfer_active` low, `sck_toggle` and `bit_tick` are both low.
- R2: While `xfer_active` is low, both outputs stay low. Dropping `xfer_active` in the middle of a bit clears all counting state.
- R3: With captured prescale code P and rate code R, the half period is H = (P+1)·2^R bus cycles. Numbering the cycles in which `xfer_active` is high from 1, `sck_toggle` is high exactly in cycles whose number is a multiple of H.
- R4: `bit_tick` is high exactly in active cycles whose number is a multiple of 2H. It is therefore always coincident with every second `sck_toggle`.
- R5: The prescale code `presc_sel` is a binary value p that selects a divide of p+1. Code 7 divides by 8.
- R6: The rate code `rate_sel` is a binary value r that selects a full-bit divide of 2^(r+1), counted over both toggles. Code 7 gives 256 prescaled ticks per bit.
- R7: Both fields are captured on every rising edge at which `xfer_active` is low. A transfer uses the values captured at the last edge before it began. Field changes while `xfer_active` is high have no effect on either output.
- R8: A transfer restarted after `xfer_active` has dropped, even in the middle of a bit, begins again with a full first half period of H cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 3 | Prescale code; the divide is code+1 |
| rate_sel | input | 3 | Rate code; the full-bit divide is 2^(code+1) |
| xfer_active | input | 1 | High while a master transfer runs |
| sck_toggle | output | 1 | One-cycle strobe at every half bit period |
| bit_tick | output | 1 | One-cycle strobe at the end of every bit period |

## Verification
Both strobes are combinational decodes of registered counter state gated by `xfer_active`. They therefore change in the same cycle that `xfer_active` rises or falls. In the first active cycle they reflect cleared counters. A strobe due at active cycle H appears H−1 clock edges after `xfer_active` goes high. The bench drives every input just after a falling edge and samples one time unit later. It numbers the active cycles itself and compares each one against H and 2H, computed from the fields it set one cycle before raising `xfer_active`. Field changes made during a transfer leave the bench's expected period unchanged, so any leak into the outputs shows up as a mismatch in that same cycle.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int SEL_W  = 3;
  localparam int RCNT_W = (1 << SEL_W) - 1;
  localparam int HALF_W = SEL_W + RCNT_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0] presc;
    logic [SEL_W-1:0] rate;
  } rate_cfg_t;
endpackage

// File: rtl/spi_presc_stage.sv
module spi_presc_stage #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             stage_tick
);
  logic [SEL_W-1:0] cnt_q;
  logic             at_end;

  assign at_end     = (cnt_q == div_sel);
  assign stage_tick = run & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || at_end)   cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_rate_stage.sv
module spi_rate_stage #(
  parameter int SEL_W  = 3,
  parameter int RCNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             in_tick,
  input  logic [SEL_W-1:0] exp_sel,
  output logic             half_tick
);
  logic [RCNT_W-1:0] cnt_q;
  logic [RCNT_W:0]   one_hot;
  logic [RCNT_W:0]   lim_w;
  logic [RCNT_W-1:0] lim;
  logic              at_end;

  assign one_hot   = {{RCNT_W{1'b0}}, 1'b1} << exp_sel;
  assign lim_w     = one_hot - 1'b1;
  assign lim       = lim_w[RCNT_W-1:0];
  assign at_end    = (cnt_q == lim);
  assign half_tick = run & in_tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (in_tick)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             xfer_active,
  output logic             sck_toggle,
  output logic             bit_tick
);
  rate_cfg_t cfg_q;
  logic      pre_tick;
  logic      half_tick;
  logic      phase_q;

  // Selections follow the inputs while idle and freeze during a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfg_q <= '0;
    else if (!xfer_active) cfg_q <= '{presc: presc_sel, rate: rate_sel};
  end

  spi_presc_stage #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(xfer_active),
    .div_sel(cfg_q.presc), .stage_tick(pre_tick)
  );

  spi_rate_stage #(.SEL_W(SEL_W), .RCNT_W(RCNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(xfer_active), .in_tick(pre_tick),
    .exp_sel(cfg_q.rate), .half_tick(half_tick)
  );

  // Phase flop selects which half of the bit the next toggle closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= 1'b0;
    else if (!xfer_active) phase_q <= 1'b0;
    else if (half_tick)    phase_q <= ~phase_q;
  end

  assign sck_toggle = half_tick;
  assign bit_tick   = half_tick & phase_q;
endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk
  import spi_rate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_active,
  input logic             sck_toggle,
  input logic             bit_tick,
  input logic [SEL_W-1:0] cfg_presc,
  input logic [SEL_W-1:0] cfg_rate
);
  logic [HALF_W-1:0] half_len;
  logic [HALF_W-1:0] gap_q;
  logic              odd_q;

  assign half_len = ({{(HALF_W-SEL_W){1'b0}}, cfg_presc} + 1'b1) << cfg_rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      odd_q <= 1'b0;
    end else if (!xfer_active) begin
      gap_q <= '0;
      odd_q <= 1'b0;
    end else if (sck_toggle) begin
      gap_q <= '0;
      odd_q <= ~odd_q;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> (!sck_toggle && !bit_tick));

  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (sck_toggle == (gap_q + 1'b1 == half_len)));

  assert_bit_on_second_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_toggle |-> (bit_tick == odd_q));

  assert_bit_implies_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sck_toggle);

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && $past(xfer_active)) |-> ($stable(cfg_presc) && $stable(cfg_rate)));
endmodule

bind spi_rate_gen spi_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
  .sck_toggle(sck_toggle), .bit_tick(bit_tick),
  .cfg_presc(cfg_q.presc), .cfg_rate(cfg_q.rate)
);

// File: tb/sim_spi_rate_gen.sv
module sim_spi_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] presc_sel = 3'd0;
  logic [2:0] rate_sel = 3'd0;
  logic       xfer_active = 1'b0;
  logic       sck_toggle;
  logic       bit_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .rate_sel(rate_sel),
    .xfer_active(xfer_active), .sck_toggle(sck_toggle), .bit_tick(bit_tick)
  );

  function automatic int half_of(int p, int r);
    return (p + 1) * (1 << r);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Runs one transfer of n active cycles; optionally scrambles fields mid-way.
  task automatic run_xfer(string req, int p, int r, int n, bit scramble, int drop_at);
    int h;
    h = half_of(p, r);
    @(negedge clk);
    presc_sel = 3'(p);
    rate_sel  = 3'(r);
    @(negedge clk);
    xfer_active = 1'b1;
    for (int i = 1; i <= n; i++) begin
      if (i > 1) @(negedge clk);
      if (scramble && (i % 3 == 0)) begin
        presc_sel = 3'($urandom_range(0, 7));
        rate_sel  = 3'($urandom_range(0, 7));
      end
      #1;
      check(req, sck_toggle, (i % h) == 0, "sck_toggle");
      check(req, bit_tick, (i % (2 * h)) == 0, "bit_tick");
      if (drop_at != 0 && i == drop_at) break;
    end
    @(negedge clk);
    xfer_active = 1'b0;
    presc_sel = 3'(p);
    rate_sel  = 3'(r);
    #1;
    check("R2", sck_toggle, 1'b0, "idle sck_toggle");
    check("R2", bit_tick, 1'b0, "idle bit_tick");
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1", sck_toggle, 1'b0, "reset sck_toggle");
    check("R1", bit_tick, 1'b0, "reset bit_tick");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R1", sck_toggle, 1'b0, "post-reset sck_toggle");
    check("R1", bit_tick, 1'b0, "post-reset bit_tick");

    // R2: fields change while idle, outputs must stay quiet.
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      presc_sel = 3'(k);
      rate_sel  = 3'(7 - k);
      #1;
      check("R2", sck_toggle | bit_tick, 1'b0, "idle outputs");
    end

    run_xfer("R3", 0, 0, 12, 1'b0, 0);
    run_xfer("R3", 2, 1, 30, 1'b0, 0);
    run_xfer("R5", 7, 0, 40, 1'b0, 0);
    run_xfer("R6", 0, 7, 520, 1'b0, 0);
    run_xfer("R4", 4, 2, 90, 1'b0, 0);
    run_xfer("R4", 7, 7, 4099, 1'b0, 0);
    run_xfer("R7", 1, 2, 60, 1'b1, 0);
    run_xfer("R7", 5, 3, 200, 1'b1, 0);
    // R8: drop mid-bit, then restart and expect a full first half period.
    run_xfer("R2", 3, 2, 21, 1'b0, 21);
    run_xfer("R8", 3, 2, 70, 1'b0, 0);
    run_xfer("R8", 6, 1, 9, 1'b0, 9);
    run_xfer("R8", 6, 1, 60, 1'b0, 0);

    for (int t = 0; t < 24; t++) begin
      int p;
      int r;
      p = $urandom_range(0, 7);
      r = $urandom_range(0, 6);
      run_xfer("R3", p, r, 4 * half_of(p, r) + 3, 1'(t % 2), 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule